// File: doc/BRIEF.md
# SMBus host controller register front end

This block is the software-visible side of an SMBus host. A processor reaches it over a byte-wide register port with separate read and write strobes. The registers hold a control byte, a command code, a target address with its direction bit, two data bytes, a block data byte and a small auxiliary control byte. A status byte reports progress and errors, and an interrupt line follows it.

A write to the control register with the start bit set does three things. It decodes the protocol selector, takes a snapshot of the transfer fields, and raises a request to a separate bus engine. The bus engine does all signalling on the wire. It answers with a one-cycle done pulse, an error flag and up to two result bytes. The front end clears the busy flag on that answer and records success or device error. For read protocols it stores the returned bytes in the data registers.

A kill write drops an outstanding request. A latched device error holds off new transfers until software clears it.

Top module: `smb_host_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, irq_o is low and req_o is low.
- R2: The command (offset 0x3), address (0x4), data0 (0x5), data1 (0x6) and block data (0x7) registers read back the last value written. The auxiliary register (0xD) reads back only its bits 1:0. Any other offset reads 0x00.
- R3: The control register (0x2) stores bit 0 (interrupt enable), bit 1 (kill) and bits 4:2 (protocol selector), and a read returns only those bits. Bit 6 (start) is never stored, so it never reads back.
- R4: A write to status (0x0) clears each of bits 7:1 that is written as 1. Bit 0 (busy) is not affected by any status write.
- R5: A start write is accepted when no request is pending, device error (status bit 2) is clear and the selector is one of 0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block or 6 I2C block read. On acceptance, req_o rises on the next cycle and carries address bits 7:1, direction bit 0 (1 = read), the selector, the command and both data bytes. Busy is set while req_o is high.
- R6: A start write with selector 4 or 7 raises no request and sets device error.
- R7: A start write while device error is already set raises no request, and device error stays set.
- R8: An error-free engine answer clears busy and sets status bit 1 (done). For reads, results are stored as follows: byte and byte-data put the low result into data0. Word puts the low result into data0 and the high result into data1. Block puts the low result (the count) into data0 and the high result into block data. I2C block read puts the low result into block data whatever the direction bit. Write and quick transfers store nothing.
- R9: An engine answer with the error flag set clears busy, sets device error and stores no result.
- R10: A control write with bit 1 set drops any pending request, clears busy and sets status bit 4 (failed). An engine answer arriving after the kill is ignored.
- R11: irq_o is high exactly when control bit 0 is set and any of status bits 7:1 is 1.
- R12: If an engine answer and a status write clearing bit 1 fall in the same cycle, bit 1 ends up set.
- R13: A start write while a request is pending is ignored, and the request fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; reads are free of side effects, so only a read marker |
| addr_i | input | AW | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |
| req_o | output | 1 | Request to the bus engine, held until answered |
| req_addr_o | output | 7 | Target address |
| req_read_o | output | 1 | Direction, 1 = read |
| req_prot_o | output | 3 | Protocol selector |
| req_cmd_o | output | 8 | Command code |
| req_data0_o | output | 8 | Data low byte |
| req_data1_o | output | 8 | Data high byte |
| rsp_done_i | input | 1 | Engine answer, one-cycle pulse |
| rsp_err_i | input | 1 | Engine error flag, valid with rsp_done_i |
| rsp_lo_i | input | 8 | Low result byte |
| rsp_hi_i | input | 8 | High result byte |

## Verification
The status register has two writers: the engine answer, which sets the done bit, and software's write-1-to-clear. The two can land on the same clock edge. The bench provokes this by driving a status write of 0x02 and the done pulse in the same cycle. It then requires status to read 0x02 and the interrupt to be high, so the new completion is not lost. A kill write can also coincide with a stale engine answer. This is judged by checking that failed is set and that no result bytes reach data0.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 5;

  localparam int OFF_STAT = 'h0;
  localparam int OFF_CTL  = 'h2;
  localparam int OFF_CMD  = 'h3;
  localparam int OFF_TGT  = 'h4;
  localparam int OFF_D0   = 'h5;
  localparam int OFF_D1   = 'h6;
  localparam int OFF_BLK  = 'h7;
  localparam int OFF_AUX  = 'hD;

  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_DEVERR = 2;
  localparam int ST_FAILED = 4;

  localparam int CT_IEN   = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_START = 6;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WORD  = 3'd3,
    PR_PCALL = 3'd4,
    PR_BLOCK = 3'd5,
    PR_I2CRD = 3'd6,
    PR_RSVD  = 3'd7
  } prot_e;

  function automatic logic prot_ok(input logic [2:0] p);
    return !(p == PR_PCALL || p == PR_RSVD);
  endfunction
endpackage

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [BYTE_W-1:0] clr_mask_i,
  input  logic              busy_set_i,
  input  logic              busy_clr_i,
  input  logic              done_set_i,
  input  logic              deverr_set_i,
  input  logic              failed_set_i,
  output logic [BYTE_W-1:0] stat_o
);
  logic [BYTE_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_we_i) stat_d[BYTE_W-1:1] = stat_q[BYTE_W-1:1] & ~clr_mask_i[BYTE_W-1:1];
    if (busy_set_i)      stat_d[ST_BUSY] = 1'b1;
    else if (busy_clr_i) stat_d[ST_BUSY] = 1'b0;
    // hardware sets win over a same-cycle software clear
    if (done_set_i)   stat_d[ST_DONE]   = 1'b1;
    if (deverr_set_i) stat_d[ST_DEVERR] = 1'b1;
    if (failed_set_i) stat_d[ST_FAILED] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/smb_host_launch.sv
module smb_host_launch
  import smb_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              start_i,
  input  logic [2:0]        prot_i,
  input  logic              dev_err_i,
  input  logic [BYTE_W-1:0] tgt_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] d0_i,
  input  logic [BYTE_W-1:0] d1_i,
  input  logic              rsp_done_i,
  input  logic              rsp_err_i,
  output logic              pend_o,
  output logic              issue_o,
  output logic              bad_o,
  output logic              ok_o,
  output logic              err_o,
  output prot_e             prot_o,
  output logic              read_o,
  output logic [BYTE_W-2:0] addr_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] d0_o,
  output logic [BYTE_W-1:0] d1_o
);
  logic pend_q;
  logic go;
  logic accept;

  // kill has priority over start and over a same-cycle answer
  assign go      = start_i && !kill_i && !pend_q && !dev_err_i;
  assign issue_o = go && prot_ok(prot_i);
  assign bad_o   = go && !prot_ok(prot_i);
  assign accept  = pend_q && rsp_done_i && !kill_i;
  assign ok_o    = accept && !rsp_err_i;
  assign err_o   = accept && rsp_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      prot_o <= PR_QUICK;
      read_o <= 1'b0;
      addr_o <= '0;
      cmd_o  <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else begin
      if (kill_i)       pend_q <= 1'b0;
      else if (issue_o) pend_q <= 1'b1;
      else if (accept)  pend_q <= 1'b0;
      if (issue_o) begin
        prot_o <= prot_e'(prot_i);
        read_o <= tgt_i[0];
        addr_o <= tgt_i[BYTE_W-1:1];
        cmd_o  <= cmd_i;
        d0_o   <= d0_i;
        d1_o   <= d1_i;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
  import smb_host_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              req_o,
  output logic [BYTE_W-2:0] req_addr_o,
  output logic              req_read_o,
  output logic [2:0]        req_prot_o,
  output logic [BYTE_W-1:0] req_cmd_o,
  output logic [BYTE_W-1:0] req_data0_o,
  output logic [BYTE_W-1:0] req_data1_o,
  input  logic              rsp_done_i,
  input  logic              rsp_err_i,
  input  logic [BYTE_W-1:0] rsp_lo_i,
  input  logic [BYTE_W-1:0] rsp_hi_i
);
  localparam int AUX_W = 2;

  logic [CTL_W-1:0]  ctl_q;
  logic [BYTE_W-1:0] cmd_q, tgt_q, d0_q, d1_q, blk_q;
  logic [AUX_W-1:0]  aux_q;
  logic [BYTE_W-1:0] stat_q;

  logic we_stat, we_ctl, we_cmd, we_tgt, we_d0, we_d1, we_blk, we_aux;
  logic kill, start;
  logic issue, bad, ok, err;
  prot_e prot_l;
  logic  read_l;
  logic  rd_unused;

  assign we_stat = wr_en_i && addr_i == AW'(OFF_STAT);
  assign we_ctl  = wr_en_i && addr_i == AW'(OFF_CTL);
  assign we_cmd  = wr_en_i && addr_i == AW'(OFF_CMD);
  assign we_tgt  = wr_en_i && addr_i == AW'(OFF_TGT);
  assign we_d0   = wr_en_i && addr_i == AW'(OFF_D0);
  assign we_d1   = wr_en_i && addr_i == AW'(OFF_D1);
  assign we_blk  = wr_en_i && addr_i == AW'(OFF_BLK);
  assign we_aux  = wr_en_i && addr_i == AW'(OFF_AUX);

  assign kill  = we_ctl && wdata_i[CT_KILL];
  assign start = we_ctl && wdata_i[CT_START];

  smb_host_launch u_launch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kill_i     (kill),
    .start_i    (start),
    .prot_i     (wdata_i[4:2]),
    .dev_err_i  (stat_q[ST_DEVERR]),
    .tgt_i      (tgt_q),
    .cmd_i      (cmd_q),
    .d0_i       (d0_q),
    .d1_i       (d1_q),
    .rsp_done_i (rsp_done_i),
    .rsp_err_i  (rsp_err_i),
    .pend_o     (req_o),
    .issue_o    (issue),
    .bad_o      (bad),
    .ok_o       (ok),
    .err_o      (err),
    .prot_o     (prot_l),
    .read_o     (read_l),
    .addr_o     (req_addr_o),
    .cmd_o      (req_cmd_o),
    .d0_o       (req_data0_o),
    .d1_o       (req_data1_o)
  );

  assign req_read_o = read_l;
  assign req_prot_o = prot_l;

  smb_host_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_we_i     (we_stat),
    .clr_mask_i   (wdata_i),
    .busy_set_i   (issue),
    .busy_clr_i   (kill || ok || err),
    .done_set_i   (ok),
    .deverr_set_i (bad || err),
    .failed_set_i (kill),
    .stat_o       (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      cmd_q <= '0;
      tgt_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
      blk_q <= '0;
      aux_q <= '0;
    end else begin
      if (we_ctl) ctl_q <= wdata_i[CTL_W-1:0];
      if (we_cmd) cmd_q <= wdata_i;
      if (we_tgt) tgt_q <= wdata_i;
      if (we_d0)  d0_q  <= wdata_i;
      if (we_d1)  d1_q  <= wdata_i;
      if (we_blk) blk_q <= wdata_i;
      if (we_aux) aux_q <= wdata_i[AUX_W-1:0];
      // engine results override a same-cycle host write
      if (ok) begin
        unique case (prot_l)
          PR_BYTE, PR_BDATA: if (read_l) d0_q <= rsp_lo_i;
          PR_WORD: if (read_l) begin
            d0_q <= rsp_lo_i;
            d1_q <= rsp_hi_i;
          end
          PR_BLOCK: if (read_l) begin
            d0_q  <= rsp_lo_i;
            blk_q <= rsp_hi_i;
          end
          PR_I2CRD: blk_q <= rsp_lo_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      AW'(OFF_STAT): rdata_o = stat_q;
      AW'(OFF_CTL):  rdata_o = BYTE_W'(ctl_q);
      AW'(OFF_CMD):  rdata_o = cmd_q;
      AW'(OFF_TGT):  rdata_o = tgt_q;
      AW'(OFF_D0):   rdata_o = d0_q;
      AW'(OFF_D1):   rdata_o = d1_q;
      AW'(OFF_BLK):  rdata_o = blk_q;
      AW'(OFF_AUX):  rdata_o = BYTE_W'(aux_q);
      default:       rdata_o = '0;
    endcase
  end

  assign rd_unused = rd_en_i;
  assign irq_o = ctl_q[CT_IEN] && |stat_q[BYTE_W-1:1];
endmodule

// File: rtl/smb_host_ctrl_chk.sv
module smb_host_ctrl_chk
  import smb_host_pkg::*;
#(
  parameter int AW = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     addr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              req_o,
  input logic [BYTE_W-2:0] req_addr_o,
  input logic [2:0]        req_prot_o,
  input logic              rsp_done_i,
  input logic              irq_o,
  input logic [BYTE_W-1:0] stat_i,
  input logic [CTL_W-1:0]  ctl_i
);
  logic ctl_wr, kill_wr, start_wr;
  assign ctl_wr   = wr_en_i && addr_i == AW'(OFF_CTL);
  assign kill_wr  = ctl_wr && wdata_i[CT_KILL];
  assign start_wr = ctl_wr && wdata_i[CT_START];

  AST_BUSY_IS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[ST_BUSY] == req_o); // R5

  AST_DEVERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr && stat_i[ST_DEVERR] && !req_o) |=> (!req_o && stat_i[ST_DEVERR])); // R7

  AST_KILL_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_wr |=> (stat_i[ST_FAILED] && !req_o)); // R10

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_i[CT_IEN]); // R11

  AST_ANSWER_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rsp_done_i && !kill_wr) |=> (!req_o && (stat_i[ST_DONE] || stat_i[ST_DEVERR]))); // R8

  AST_REQ_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> ($stable(req_prot_o) && $stable(req_addr_o))); // R13
endmodule

bind smb_host_ctrl smb_host_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .req_o      (req_o),
  .req_addr_o (req_addr_o),
  .req_prot_o (req_prot_o),
  .rsp_done_i (rsp_done_i),
  .irq_o      (irq_o),
  .stat_i     (stat_q),
  .ctl_i      (ctl_q)
);

// File: tb/smb_host_ctrl_tb.sv
module smb_host_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, req, req_read;
  logic [6:0] req_addr;
  logic [2:0] req_prot;
  logic [7:0] req_cmd, req_d0, req_d1;
  logic       rsp_done = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_lo = '0, rsp_hi = '0;

  int vecs = 0;
  int errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_ctrl #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .req_o(req), .req_addr_o(req_addr), .req_read_o(req_read),
    .req_prot_o(req_prot), .req_cmd_o(req_cmd), .req_data0_o(req_d0),
    .req_data1_o(req_d1), .rsp_done_i(rsp_done), .rsp_err_i(rsp_err),
    .rsp_lo_i(rsp_lo), .rsp_hi_i(rsp_hi)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rsp(input logic e, input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    rsp_done = 1'b1; rsp_err = e; rsp_lo = lo; rsp_hi = hi;
    @(negedge clk);
    rsp_done = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1 status", 4'h0, 8'h00);
    chk_reg("R1 control", 4'h2, 8'h00);
    chk_reg("R1 data0", 4'h5, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 req", {7'd0, req}, 8'h00);
  endtask

  task automatic t_regs;
    wr(4'h3, 8'hA5); wr(4'h4, 8'h3C); wr(4'h5, 8'h81);
    wr(4'h6, 8'h7E); wr(4'h7, 8'hC3); wr(4'hD, 8'hFF);
    chk_reg("R2 cmd", 4'h3, 8'hA5);
    chk_reg("R2 addr", 4'h4, 8'h3C);
    chk_reg("R2 data0", 4'h5, 8'h81);
    chk_reg("R2 data1", 4'h6, 8'h7E);
    chk_reg("R2 blk", 4'h7, 8'hC3);
    chk_reg("R2 aux", 4'hD, 8'h03);
    chk_reg("R2 unmapped8", 4'h8, 8'h00);
    chk_reg("R2 unmapped1", 4'h1, 8'h00);
  endtask

  task automatic t_ctrl;
    wr(4'h2, 8'hBC);
    chk_reg("R3 ctrl mask", 4'h2, 8'h1C);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_word_read;
    wr(4'h4, 8'h5B); wr(4'h3, 8'h33); wr(4'h5, 8'h00); wr(4'h6, 8'h00);
    wr(4'h2, 8'h4C);
    chk_reg("R3 start not read", 4'h2, 8'h0C);
    chk("R5 req", {7'd0, req}, 8'h01);
    chk("R5 addr", {1'b0, req_addr}, 8'h2D);
    chk("R5 read", {7'd0, req_read}, 8'h01);
    chk("R5 prot", {5'd0, req_prot}, 8'h03);
    chk("R5 cmd", req_cmd, 8'h33);
    chk_reg("R5 busy", 4'h0, 8'h01);
    wr(4'h2, 8'h44);
    chk("R13 prot held", {5'd0, req_prot}, 8'h03);
    chk_reg("R13 status", 4'h0, 8'h01);
    rsp(1'b0, 8'h11, 8'h22);
    chk_reg("R8 status", 4'h0, 8'h02);
    chk_reg("R8 word lo", 4'h5, 8'h11);
    chk_reg("R8 word hi", 4'h6, 8'h22);
    chk("R8 req drop", {7'd0, req}, 8'h00);
    chk("R11 irq disabled", {7'd0, irq}, 8'h00);
    wr(4'h0, 8'h02);
    chk_reg("R4 clear done", 4'h0, 8'h00);
  endtask

  task automatic t_byte_write;
    wr(4'h4, 8'h5A); wr(4'h5, 8'h77); wr(4'h6, 8'h66);
    wr(4'h2, 8'h49);
    chk("R5 write dir", {7'd0, req_read}, 8'h00);
    chk("R5 data0", req_d0, 8'h77);
    chk("R5 data1", req_d1, 8'h66);
    chk("R5 prot", {5'd0, req_prot}, 8'h02);
    chk("R11 busy only", {7'd0, irq}, 8'h00);
    wr(4'h0, 8'hFF);
    chk_reg("R4 busy kept", 4'h0, 8'h01);
    rsp(1'b0, 8'hEE, 8'hDD);
    chk_reg("R8 write no capture", 4'h5, 8'h77);
    chk_reg("R8 status", 4'h0, 8'h02);
    chk("R11 irq on", {7'd0, irq}, 8'h01);
    wr(4'h0, 8'h02);
    chk("R11 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_bad_prot;
    wr(4'h2, 8'h50);
    chk_reg("R6 deverr", 4'h0, 8'h04);
    chk("R6 no req", {7'd0, req}, 8'h00);
    wr(4'h2, 8'h44);
    chk("R7 no req", {7'd0, req}, 8'h00);
    chk_reg("R7 deverr kept", 4'h0, 8'h04);
    wr(4'h0, 8'hFE);
    wr(4'h2, 8'h5C);
    chk_reg("R6 sel7", 4'h0, 8'h04);
    chk("R6 sel7 no req", {7'd0, req}, 8'h00);
    wr(4'h0, 8'hFE);
  endtask

  task automatic t_engine_err;
    wr(4'h5, 8'h55); wr(4'h4, 8'h5B);
    wr(4'h2, 8'h44);
    chk("R9 req", {7'd0, req}, 8'h01);
    rsp(1'b1, 8'hAA, 8'hBB);
    chk_reg("R9 status", 4'h0, 8'h04);
    chk_reg("R9 no capture", 4'h5, 8'h55);
    wr(4'h0, 8'hFE);
  endtask

  task automatic t_kill;
    wr(4'h2, 8'h44);
    chk("R10 req up", {7'd0, req}, 8'h01);
    wr(4'h2, 8'h02);
    chk("R10 req dropped", {7'd0, req}, 8'h00);
    chk_reg("R10 failed", 4'h0, 8'h10);
    rsp(1'b0, 8'h99, 8'h00);
    chk_reg("R10 late answer status", 4'h0, 8'h10);
    chk_reg("R10 late answer data0", 4'h5, 8'h55);
    wr(4'h2, 8'h00);
    wr(4'h0, 8'hFE);
    chk_reg("R4 cleared", 4'h0, 8'h00);
  endtask

  task automatic t_blocks;
    wr(4'h4, 8'h55);
    wr(4'h2, 8'h54);
    rsp(1'b0, 8'h04, 8'h9C);
    chk_reg("R8 block count", 4'h5, 8'h04);
    chk_reg("R8 block byte", 4'h7, 8'h9C);
    wr(4'h0, 8'hFE);
    wr(4'h4, 8'h54);
    wr(4'h2, 8'h58);
    chk("R5 i2c prot", {5'd0, req_prot}, 8'h06);
    rsp(1'b0, 8'h3E, 8'h00);
    chk_reg("R8 i2c block byte", 4'h7, 8'h3E);
    chk_reg("R8 i2c status", 4'h0, 8'h02);
    wr(4'h0, 8'hFE);
  endtask

  task automatic t_collide;
    wr(4'h2, 8'h41);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h0; wdata = 8'h02; rsp_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rsp_done = 1'b0;
    chk_reg("R12 done survives", 4'h0, 8'h02);
    chk("R12 irq", {7'd0, irq}, 8'h01);
    wr(4'h0, 8'h02);
    chk("R11 irq clear", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ctrl();
    t_word_read();
    t_byte_write();
    t_bad_prot();
    t_engine_err();
    t_kill();
    t_blocks();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule